// File: doc/BRIEF.md
# GPIO Pin Interrupt and Trigger Controller

This block watches the eight input pins of a general-purpose I/O port and turns their activity into interrupt requests and converter/transfer start pulses. Each pin is sampled through a two-flop synchroniser. A small register set, reached over a synchronous single-cycle bus, chooses per pin whether it is edge- or level-sensitive, which polarity counts, and whether both edges count. It also gates each pin onto the interrupt lines and onto two trigger outputs.

Software reads a raw status word showing every pin that meets its condition, and a masked status word showing only the pins allowed to interrupt. Edge-detected status is sticky until software clears it with a write-one-to-clear. Level-detected status follows the pin and cannot be cleared. The block drives one interrupt line per pin, a combined port interrupt, and single-cycle start pulses to an analogue-to-digital converter and a DMA engine, each with its own per-pin enable word.

Top module: `pinint_ctrl`

## Requirements
- R1: After reset every register reads zero and every output is low. The register offsets are: 0 sense-select, 1 both-edges, 2 polarity, 3 interrupt enable (mask), 4 raw status (read only), 5 masked status (read only), 6 clear (write-one-to-clear, reads zero), 7 ADC trigger enable, 8 DMA trigger enable. A read returns data on the bus one clock after the address is presented.
- R2: A pin with sense-select bit 0 and both-edges bit 0 is edge-sensed. Its raw status bit is set on a rising edge when its polarity bit is 1, and on a falling edge when its polarity bit is 0.
- R3: An edge-sensed pin with both-edges bit 1 sets its raw status bit on either edge, whatever its polarity bit.
- R4: A pin with sense-select bit 1 has a raw status bit equal to its synchronised level when polarity is 1, and to the inverted level when polarity is 0. The bit clears by itself when the pin leaves the active level, and writes to the clear register do not change it.
- R5: An edge-sensed raw status bit stays set until a 1 is written to the same bit of the clear register. Writing 0 to that bit leaves it set.
- R6: The masked status register reads as the raw status ANDed with the interrupt enable register.
- R7: Each per-pin interrupt output equals that pin's masked status, delayed by one register stage. The port interrupt is the OR of all per-pin interrupt outputs.
- R8: The ADC trigger output for a pin pulses high for exactly one cycle when that pin's raw status rises, provided both its enable (mask) bit and its ADC enable bit were set.
- R9: The DMA trigger output behaves as in R8, gated by the DMA enable register instead of the ADC enable register.
- R10: A configuration write that makes an edge-sensed pin's active condition become true sets its raw status bit, even though the pin itself did not move.
- R11: When an edge event and a clearing write for the same pin fall in the same cycle, the raw status bit ends up set.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| pin_i | input | NPINS | Asynchronous pin inputs |
| bus_addr | input | 4 | Register offset |
| bus_we | input | 1 | Write strobe, one cycle per write |
| bus_wdata | input | NPINS | Write data |
| bus_rdata | output | NPINS | Read data, registered |
| irq_pin_o | output | NPINS | Per-pin interrupt lines |
| port_irq_o | output | 1 | Combined port interrupt |
| adc_trig_o | output | NPINS | Per-pin converter start pulses |
| dma_trig_o | output | NPINS | Per-pin DMA start pulses |

## Verification
The properties assume that the synchroniser absorbs the pin inputs, so a level-sensed raw bit can be compared with the condition seen one cycle earlier. They also assume that a raw bit cannot fall and rise again in consecutive cycles, which holds because the pins reach the detector only through registered samples. Each property is enabled only once a full cycle has passed since reset, so no $past reaches back to values from before reset. The stimulus moves pins and issues bus writes only on falling clock edges and holds each pin pattern for several cycles before sampling. The one deliberate same-cycle collision of an edge and a clear is placed by counting the synchroniser stages.

// File: rtl/pinint_pkg.sv
package pinint_pkg;
  localparam int unsigned ADDR_W = 4;

  typedef enum logic [ADDR_W-1:0] {
    OFS_SENSE  = 4'd0,
    OFS_BOTH   = 4'd1,
    OFS_POL    = 4'd2,
    OFS_MASK   = 4'd3,
    OFS_RAW    = 4'd4,
    OFS_MSTAT  = 4'd5,
    OFS_CLEAR  = 4'd6,
    OFS_ADC_EN = 4'd7,
    OFS_DMA_EN = 4'd8
  } reg_ofs_e;
endpackage

// File: rtl/pinint_sync.sv
module pinint_sync #(
  parameter int unsigned W      = 8,
  parameter int unsigned STAGES = 2
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [STAGES-1:0][W-1:0] chain;

  always_ff @(posedge clk) begin
    if (rst) begin
      chain <= '0;
    end else begin
      chain[0] <= d;
      for (int s = 1; s < int'(STAGES); s++) chain[s] <= chain[s-1];
    end
  end

  assign q = chain[STAGES-1];
endmodule

// File: rtl/pinint_detect.sv
module pinint_detect #(
  parameter int unsigned NPINS = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [NPINS-1:0] samp,
  input  logic [NPINS-1:0] sense,
  input  logic [NPINS-1:0] both,
  input  logic [NPINS-1:0] pol,
  input  logic [NPINS-1:0] clr,
  output logic [NPINS-1:0] cond,
  output logic [NPINS-1:0] raw
);
  for (genvar p = 0; p < NPINS; p++) begin : g_pin
    logic cond_q;
    logic samp_q;
    logic raw_r;
    logic hit;

    // active condition: level when pol=1, inverted level when pol=0
    assign cond[p] = ~(samp[p] ^ pol[p]);

    always_comb begin
      if (both[p]) hit = samp[p] ^ samp_q;
      else         hit = cond[p] & ~cond_q;
    end

    always_ff @(posedge clk) begin
      if (rst) begin
        cond_q <= 1'b1;   // matches low pin with falling polarity after reset
        samp_q <= 1'b0;
        raw_r  <= 1'b0;
      end else begin
        cond_q <= cond[p];
        samp_q <= samp[p];
        if (sense[p])    raw_r <= cond[p];
        else if (hit)    raw_r <= 1'b1;
        else if (clr[p]) raw_r <= 1'b0;
      end
    end

    assign raw[p] = raw_r;
  end
endmodule

// File: rtl/pinint_regs.sv
module pinint_regs
  import pinint_pkg::*;
#(
  parameter int unsigned NPINS = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [ADDR_W-1:0] addr,
  input  logic              we,
  input  logic [NPINS-1:0]  wdata,
  input  logic [NPINS-1:0]  raw,
  input  logic [NPINS-1:0]  mstat,
  output logic [NPINS-1:0]  sense,
  output logic [NPINS-1:0]  both,
  output logic [NPINS-1:0]  pol,
  output logic [NPINS-1:0]  mask,
  output logic [NPINS-1:0]  adc_en,
  output logic [NPINS-1:0]  dma_en,
  output logic [NPINS-1:0]  clr,
  output logic [NPINS-1:0]  rdata
);
  reg_ofs_e ofs;
  logic [NPINS-1:0] rd_next;

  assign ofs = reg_ofs_e'(addr);
  assign clr = (we && ofs == OFS_CLEAR) ? wdata : '0;

  always_ff @(posedge clk) begin
    if (rst) begin
      sense  <= '0;
      both   <= '0;
      pol    <= '0;
      mask   <= '0;
      adc_en <= '0;
      dma_en <= '0;
    end else if (we) begin
      case (ofs)
        OFS_SENSE:  sense  <= wdata;
        OFS_BOTH:   both   <= wdata;
        OFS_POL:    pol    <= wdata;
        OFS_MASK:   mask   <= wdata;
        OFS_ADC_EN: adc_en <= wdata;
        OFS_DMA_EN: dma_en <= wdata;
        default:    ;
      endcase
    end
  end

  always_comb begin
    case (ofs)
      OFS_SENSE:  rd_next = sense;
      OFS_BOTH:   rd_next = both;
      OFS_POL:    rd_next = pol;
      OFS_MASK:   rd_next = mask;
      OFS_RAW:    rd_next = raw;
      OFS_MSTAT:  rd_next = mstat;
      OFS_ADC_EN: rd_next = adc_en;
      OFS_DMA_EN: rd_next = dma_en;
      default:    rd_next = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) rdata <= '0;
    else     rdata <= rd_next;
  end
endmodule

// File: rtl/pinint_out.sv
module pinint_out #(
  parameter int unsigned NPINS = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [NPINS-1:0] raw,
  input  logic [NPINS-1:0] mask,
  input  logic [NPINS-1:0] adc_en,
  input  logic [NPINS-1:0] dma_en,
  output logic [NPINS-1:0] irq_pin,
  output logic             port_irq,
  output logic [NPINS-1:0] adc_trig,
  output logic [NPINS-1:0] dma_trig
);
  logic [NPINS-1:0] raw_d;
  logic [NPINS-1:0] rise_q;

  assign rise_q = raw & ~raw_d & mask;

  always_ff @(posedge clk) begin
    if (rst) begin
      raw_d    <= '0;
      irq_pin  <= '0;
      port_irq <= 1'b0;
      adc_trig <= '0;
      dma_trig <= '0;
    end else begin
      raw_d    <= raw;
      irq_pin  <= raw & mask;
      port_irq <= |(raw & mask);
      adc_trig <= rise_q & adc_en;
      dma_trig <= rise_q & dma_en;
    end
  end
endmodule

// File: rtl/pinint_ctrl.sv
module pinint_ctrl
  import pinint_pkg::*;
#(
  parameter int unsigned NPINS       = 8,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [NPINS-1:0]  pin_i,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic              bus_we,
  input  logic [NPINS-1:0]  bus_wdata,
  output logic [NPINS-1:0]  bus_rdata,
  output logic [NPINS-1:0]  irq_pin_o,
  output logic              port_irq_o,
  output logic [NPINS-1:0]  adc_trig_o,
  output logic [NPINS-1:0]  dma_trig_o
);
  logic [NPINS-1:0] samp;
  logic [NPINS-1:0] cond_w;
  logic [NPINS-1:0] raw_q;
  logic [NPINS-1:0] mstat_w;
  logic [NPINS-1:0] sense_q, both_q, pol_q, mask_q;
  logic [NPINS-1:0] adc_en_q, dma_en_q;
  logic [NPINS-1:0] clr_w;

  assign mstat_w = raw_q & mask_q;

  pinint_sync #(.W(NPINS), .STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst(rst), .d(pin_i), .q(samp)
  );

  pinint_detect #(.NPINS(NPINS)) u_detect (
    .clk(clk), .rst(rst), .samp(samp), .sense(sense_q), .both(both_q),
    .pol(pol_q), .clr(clr_w), .cond(cond_w), .raw(raw_q)
  );

  pinint_regs #(.NPINS(NPINS)) u_regs (
    .clk(clk), .rst(rst), .addr(bus_addr), .we(bus_we), .wdata(bus_wdata),
    .raw(raw_q), .mstat(mstat_w), .sense(sense_q), .both(both_q), .pol(pol_q),
    .mask(mask_q), .adc_en(adc_en_q), .dma_en(dma_en_q), .clr(clr_w),
    .rdata(bus_rdata)
  );

  pinint_out #(.NPINS(NPINS)) u_out (
    .clk(clk), .rst(rst), .raw(raw_q), .mask(mask_q), .adc_en(adc_en_q),
    .dma_en(dma_en_q), .irq_pin(irq_pin_o), .port_irq(port_irq_o),
    .adc_trig(adc_trig_o), .dma_trig(dma_trig_o)
  );
endmodule

// File: rtl/pinint_checker.sv
module pinint_checker #(
  parameter int unsigned NPINS = 8
) (
  input logic             clk,
  input logic             rst,
  input logic [NPINS-1:0] raw,
  input logic [NPINS-1:0] mask,
  input logic [NPINS-1:0] sense,
  input logic [NPINS-1:0] cond,
  input logic [NPINS-1:0] clr,
  input logic [NPINS-1:0] adc_en,
  input logic [NPINS-1:0] dma_en,
  input logic [NPINS-1:0] irq_pin_o,
  input logic             port_irq_o,
  input logic [NPINS-1:0] adc_trig_o,
  input logic [NPINS-1:0] dma_trig_o
);
  logic warm;
  always_ff @(posedge clk) begin
    if (rst) warm <= 1'b0;
    else     warm <= 1'b1;
  end

  p_level_follow_r4: assert property (@(posedge clk) disable iff (rst || !warm)
    (($past(sense) & (raw ^ $past(cond))) == '0));

  p_edge_sticky_r5: assert property (@(posedge clk) disable iff (rst || !warm)
    (($past(~sense & raw & ~clr) & ~raw) == '0));

  p_pin_irq_r7: assert property (@(posedge clk) disable iff (rst || !warm)
    irq_pin_o == $past(raw & mask));

  p_port_or_r7: assert property (@(posedge clk) disable iff (rst || !warm)
    port_irq_o == (|irq_pin_o));

  p_adc_gate_r8: assert property (@(posedge clk) disable iff (rst || !warm)
    ((adc_trig_o & ~$past(mask & adc_en)) == '0));

  p_adc_single_r8: assert property (@(posedge clk) disable iff (rst || !warm)
    ((adc_trig_o & $past(adc_trig_o)) == '0));

  p_dma_gate_r9: assert property (@(posedge clk) disable iff (rst || !warm)
    ((dma_trig_o & ~$past(mask & dma_en)) == '0));

  p_dma_single_r9: assert property (@(posedge clk) disable iff (rst || !warm)
    ((dma_trig_o & $past(dma_trig_o)) == '0));
endmodule

bind pinint_ctrl pinint_checker #(.NPINS(NPINS)) u_chk (
  .clk(clk), .rst(rst), .raw(raw_q), .mask(mask_q), .sense(sense_q),
  .cond(cond_w), .clr(clr_w), .adc_en(adc_en_q), .dma_en(dma_en_q),
  .irq_pin_o(irq_pin_o), .port_irq_o(port_irq_o),
  .adc_trig_o(adc_trig_o), .dma_trig_o(dma_trig_o)
);

// File: tb/pinint_ctrl_bench.sv
module pinint_ctrl_bench;
  localparam int CLK_PERIOD = 10;
  localparam int N = 8;

  logic         clk = 1'b0;
  logic         rst = 1'b1;
  logic [N-1:0] pin_i = '0;
  logic [3:0]   bus_addr = '0;
  logic         bus_we = 1'b0;
  logic [N-1:0] bus_wdata = '0;
  logic [N-1:0] bus_rdata, irq_pin_o, adc_trig_o, dma_trig_o;
  logic         port_irq_o;

  int checks = 0;
  int fails  = 0;
  bit done   = 0;
  int adc_cnt = 0, dma_cnt = 0;
  logic [N-1:0] adc_seen = '0, dma_seen = '0;

  always #(CLK_PERIOD/2) clk = ~clk;

  pinint_ctrl #(.NPINS(N)) u_pinint_ctrl (
    .clk(clk), .rst(rst), .pin_i(pin_i), .bus_addr(bus_addr), .bus_we(bus_we),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .irq_pin_o(irq_pin_o),
    .port_irq_o(port_irq_o), .adc_trig_o(adc_trig_o), .dma_trig_o(dma_trig_o)
  );

  always @(negedge clk) begin
    if (!rst) begin
      adc_cnt  = adc_cnt + $countones(adc_trig_o);
      dma_cnt  = dma_cnt + $countones(dma_trig_o);
      adc_seen = adc_seen | adc_trig_o;
      dma_seen = dma_seen | dma_trig_o;
    end
  end

  // fields: level, both, pol, p0, p1, expected raw
  localparam logic [26:0] VEC [8] = '{
    {1'b0, 1'b0, 1'b1, 8'h00, 8'h0F, 8'h0F},
    {1'b0, 1'b0, 1'b0, 8'hFF, 8'hF0, 8'h0F},
    {1'b0, 1'b1, 1'b0, 8'hAA, 8'h55, 8'hFF},
    {1'b0, 1'b1, 1'b1, 8'h3C, 8'h3C, 8'h00},
    {1'b1, 1'b0, 1'b1, 8'h00, 8'hA5, 8'hA5},
    {1'b1, 1'b0, 1'b0, 8'hFF, 8'hA5, 8'h5A},
    {1'b0, 1'b0, 1'b1, 8'hFF, 8'h00, 8'h00},
    {1'b0, 1'b0, 1'b0, 8'h00, 8'h81, 8'h00}
  };

  task automatic check(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic wait_cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wr(input logic [3:0] a, input logic [N-1:0] d);
    @(negedge clk);
    bus_addr = a; bus_wdata = d; bus_we = 1'b1;
    @(negedge clk);
    bus_we = 1'b0;
  endtask

  task automatic rd(input logic [3:0] a, output logic [N-1:0] d);
    @(negedge clk);
    bus_addr = a; bus_we = 1'b0;
    @(negedge clk);
    d = bus_rdata;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      fails++; checks++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  initial begin
    logic [N-1:0] v;
    wait_cyc(4);
    rst = 1'b0;
    wait_cyc(2);

    // R1 reset state
    for (int a = 0; a < 9; a++) begin
      rd(4'(a), v);
      check("R1 reg", int'(v), 0);
    end
    check("R1 irq", int'(irq_pin_o), 0);
    check("R1 port", int'(port_irq_o), 0);
    check("R1 trig", int'(adc_trig_o | dma_trig_o), 0);

    // vector table: R2 R3 R4 R6
    wr(4'd3, 8'hFF);
    for (int i = 0; i < 8; i++) begin
      string tag;
      logic [26:0] e;
      e = VEC[i];
      tag = e[26] ? "R4" : (e[25] ? "R3" : "R2");
      wr(4'd0, {N{e[26]}});
      wr(4'd1, {N{e[25]}});
      wr(4'd2, {N{e[24]}});
      pin_i = e[23:16];
      wait_cyc(6);
      wr(4'd6, 8'hFF);
      pin_i = e[15:8];
      wait_cyc(6);
      rd(4'd4, v);
      check(tag, int'(v), int'(e[7:0]));
      rd(4'd5, v);
      check("R6 mstat", int'(v), int'(e[7:0]));
    end

    // R5 sticky edge status and write-one-to-clear
    wr(4'd0, 8'h00); wr(4'd1, 8'h00); wr(4'd2, 8'hFF);
    pin_i = 8'h00; wait_cyc(6); wr(4'd6, 8'hFF);
    pin_i = 8'h03; wait_cyc(6);
    rd(4'd4, v); check("R5 set", int'(v), 8'h03);
    wr(4'd6, 8'h00); wait_cyc(2);
    rd(4'd4, v); check("R5 zero write", int'(v), 8'h03);
    wr(4'd6, 8'h01); wait_cyc(2);
    rd(4'd4, v); check("R5 clear one", int'(v), 8'h02);
    rd(4'd6, v); check("R1 clear reads zero", int'(v), 0);

    // R4 level status ignores clear and self-clears
    wr(4'd0, 8'hFF); wr(4'd2, 8'hFF);
    pin_i = 8'h03; wait_cyc(6);
    wr(4'd6, 8'hFF); wait_cyc(2);
    rd(4'd4, v); check("R4 clear ignored", int'(v), 8'h03);
    pin_i = 8'h01; wait_cyc(6);
    rd(4'd4, v); check("R4 self clear", int'(v), 8'h01);

    // R6 R7 R8 R9 masking and triggers
    wr(4'd0, 8'h00); wr(4'd1, 8'h00); wr(4'd2, 8'hFF);
    pin_i = 8'h00; wait_cyc(6); wr(4'd6, 8'hFF);
    wr(4'd3, 8'h0F); wr(4'd7, 8'h33); wr(4'd8, 8'hC6);
    wait_cyc(2);
    adc_cnt = 0; dma_cnt = 0; adc_seen = '0; dma_seen = '0;
    pin_i = 8'hFF; wait_cyc(8);
    rd(4'd4, v); check("R2 raw all", int'(v), 8'hFF);
    rd(4'd5, v); check("R6 masked", int'(v), 8'h0F);
    check("R7 pin irq", int'(irq_pin_o), 8'h0F);
    check("R7 port irq", int'(port_irq_o), 1);
    check("R8 adc pins", int'(adc_seen), 8'h03);
    check("R8 adc count", adc_cnt, 2);
    check("R9 dma pins", int'(dma_seen), 8'h06);
    check("R9 dma count", dma_cnt, 2);
    wr(4'd3, 8'h00); wait_cyc(2);
    check("R7 port off", int'(port_irq_o), 0);
    check("R7 pins off", int'(irq_pin_o), 0);

    // R10 configuration write sets status
    wr(4'd3, 8'hFF); wr(4'd2, 8'hFF);
    pin_i = 8'h00; wait_cyc(6); wr(4'd6, 8'hFF); wait_cyc(1);
    rd(4'd4, v); check("R10 before", int'(v), 8'h00);
    wr(4'd2, 8'h00); wait_cyc(2);
    rd(4'd4, v); check("R10 spurious", int'(v), 8'hFF);

    // R11 edge and clear in the same cycle
    wr(4'd1, 8'h01);
    pin_i = 8'h00; wait_cyc(6); wr(4'd6, 8'hFF);
    pin_i = 8'h01; wait_cyc(6);
    rd(4'd4, v); check("R3 pin0 rise", int'(v), 8'h01);
    @(negedge clk); pin_i = 8'h00;   // sync stage 1 at next edge
    @(negedge clk);                    // sync stage 2
    @(negedge clk);
    bus_addr = 4'd6; bus_wdata = 8'h01; bus_we = 1'b1;  // lands with the edge
    @(negedge clk); bus_we = 1'b0;
    rd(4'd4, v); check("R11 event wins", int'(v), 8'h01);
    wr(4'd6, 8'h01); wait_cyc(1);
    rd(4'd4, v); check("R5 later clear", int'(v), 8'h00);

    done = 1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule